// File: doc/BRIEF.md
# Byte-Lane Static Memory With Triple Chip Select

This block is a synthesizable functional model of an asynchronous static memory whose 24-bit word is split into three 8-bit lanes. Three chip-select inputs of mixed polarity must all be in their active state before the memory responds. Two are active low and one is active high. An active-low write strobe, an active-low output enable and three active-low lane enables then choose one of five modes: standby, output disabled, word read, lane-masked read, or word or lane-masked write.

Tri-state pins are modelled as a plain read-data bus plus one drive flag per lane. A lane whose flag is low carries zero. Reads are combinational from the array. A write is committed on the rising clock edge while the strobe is held low. The depth is a parameter and the address width follows from it. The native configuration is a depth of 131072, which gives a 17-bit address. The default is kept small so that the model elaborates quickly, and a bench can shrink it further.

Top module: `tl_sram`

## Requirements
- R1: The memory is selected only when `cs0_ni` is 0, `cs1_ni` is 0 and `cs2_i` is 1. `standby_o` is 1 exactly when it is not selected.
- R2: While deselected, `drive_o` is 000 and `rdata_o` is 0, whatever `we_ni`, `oe_ni` and `be_ni` are, and no rising edge changes stored data.
- R3: When selected with `we_ni` at 0, each lane whose `be_ni` bit is 0 stores its slice of `wdata_i` at `addr_i` on the rising edge of `clk_i`. The value of `oe_ni` has no effect on this.
- R4: During a write, a lane whose `be_ni` bit is 1 keeps its stored contents.
- R5: When selected with `we_ni` at 1 and `oe_ni` at 0, `drive_o[i]` equals the inverse of `be_ni[i]`. Each driven lane shows the stored slice at `addr_i` in the same cycle.
- R6: Every lane whose `drive_o` bit is 0 reads as zero on `rdata_o`.
- R7: When selected with `we_ni` at 1 and `oe_ni` at 1, `drive_o` is 000 and `standby_o` is 0.
- R8: While a write is in progress (selected with `we_ni` at 0), `drive_o` is 000.
- R9: Lane 0 (`be_ni[0]`) covers bits 7:0, lane 1 covers bits 15:8 and lane 2 covers bits 23:16. This applies to both reads and writes.
- R10: While `rst_ni` is 0, no write is committed.
- R11: `addr_i` is `ADDR_W` = clog2(`DEPTH`) bits wide. Each word up to `DEPTH`-1, including the first and the last, is stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write commit clock |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks writes |
| addr_i | input | ADDR_W | Word address |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| be_ni | input | 3 | Lane enables, active low, bit i for lane i |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data, zero in undriven lanes |
| drive_o | output | 3 | Per-lane drive flag replacing tri-state |
| standby_o | output | 1 | High when the memory is not selected |

## Verification
The bench targets partial selects in which only one of the three chip selects is wrong. A decoder that ignores the active-high select, or that treats it as active low, would drive data or accept writes while it should sit in standby. Masked writes are followed by full-word reads, so a swapped lane mapping or a write that ignores the lane mask shows up as corrupted neighbour bytes. The bench also covers writes with `oe_ni` low, the output-disabled mode, accesses to the first and last word, and writes attempted during reset. A design that got any of these wrong would drive the bus during a write, report standby while merely output-disabled, alias addresses, or commit data while reset is held.

// File: rtl/tl_sram_pkg.sv
package tl_sram_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OFF     = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } tl_mode_e;
endpackage

// File: rtl/tl_ctrl_decode.sv
module tl_ctrl_decode
  import tl_sram_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  logic             cs0_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [LANES-1:0] be_ni,
  output tl_mode_e         mode_o,
  output logic [LANES-1:0] wr_lane_o,
  output logic             standby_o
);
  logic sel;

  assign sel = ~cs0_ni & ~cs1_ni & cs2_i;

  always_comb begin
    if (!sel)        mode_o = MODE_STANDBY;
    else if (!we_ni) mode_o = MODE_WRITE;  // output enable ignored
    else if (!oe_ni) mode_o = MODE_READ;
    else             mode_o = MODE_OFF;
  end

  assign wr_lane_o = (mode_o == MODE_WRITE) ? ~be_ni : '0;
  assign standby_o = (mode_o == MODE_STANDBY);
endmodule

// File: rtl/tl_lane_store.sv
module tl_lane_store #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tl_out_gate.sv
module tl_out_gate
  import tl_sram_pkg::*;
#(
  parameter int unsigned LANES = 3,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  tl_mode_e          mode_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic [WORD_W-1:0] array_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LANES-1:0]  drive_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign drive_o[i] = (mode_i == MODE_READ) & ~be_ni[i];
    assign rdata_o[i*LANE_W +: LANE_W] = drive_o[i] ? array_i[i*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/tl_sram.sv
module tl_sram
  import tl_sram_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned LANES  = 3,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs0_ni,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LANES-1:0]  drive_o,
  output logic              standby_o
);
  tl_mode_e          mode;
  logic [LANES-1:0]  wr_lane;
  logic [WORD_W-1:0] array_word;

  tl_ctrl_decode #(.LANES(LANES)) u_dec (
    .cs0_ni    (cs0_ni),
    .cs1_ni    (cs1_ni),
    .cs2_i     (cs2_i),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .be_ni     (be_ni),
    .mode_o    (mode),
    .wr_lane_o (wr_lane),
    .standby_o (standby_o)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_store
    tl_lane_store #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .DATA_W (LANE_W)
    ) u_store (
      .clk_i   (clk_i),
      .we_i    (wr_lane[i] & rst_ni),  // reset holds off commits
      .addr_i  (addr_i),
      .wdata_i (wdata_i[i*LANE_W +: LANE_W]),
      .rdata_o (array_word[i*LANE_W +: LANE_W])
    );
  end

  tl_out_gate #(.LANES(LANES)) u_gate (
    .mode_i  (mode),
    .be_ni   (be_ni),
    .array_i (array_word),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/tl_sram_checker.sv
module tl_sram_checker #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned ADDR_W = 11,
  localparam int unsigned WORD_W = LANES * 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cs0_ni,
  input logic              cs1_ni,
  input logic              cs2_i,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [LANES-1:0]  be_ni,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic [LANES-1:0]  drive_o,
  input logic              standby_o
);
  logic sel;
  assign sel = !cs0_ni && !cs1_ni && cs2_i;

  a_r2_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (drive_o == '0 && rdata_o == '0));

  a_r8_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !we_ni) |-> (drive_o == '0 && !standby_o));

  a_r7_off_not_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && we_ni && oe_ni) |-> (drive_o == '0 && !standby_o));

  a_r5_read_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && we_ni && !oe_ni) |-> (drive_o == ~be_ni));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    a_r6_idle_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drive_o[i] |-> (rdata_o[i*8 +: 8] == 8'h00));

    a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !we_ni && !be_ni[i]) |=>
        (!(addr_i == $past(addr_i) && drive_o[i]) ||
         rdata_o[i*8 +: 8] == $past(wdata_i[i*8 +: 8])));
  end
endmodule

bind tl_sram tl_sram_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tl_sram_test.sv
`timescale 1ns/1ps
module tl_sram_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs0_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0;
  logic          we_n = 1'b1, oe_n = 1'b1;
  logic [2:0]    be_n = 3'b111;
  logic [23:0]   wdata = '0;
  logic [23:0]   rdata;
  logic [2:0]    drive;
  logic          standby;

  logic [23:0] shadow [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tl_sram #(.DEPTH(DEPTH)) uut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr),
    .cs0_ni (cs0_n), .cs1_ni (cs1_n), .cs2_i (cs2),
    .we_ni (we_n), .oe_ni (oe_n), .be_ni (be_n), .wdata_i (wdata),
    .rdata_o (rdata), .drive_o (drive), .standby_o (standby)
  );

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_drive(logic s, logic w, logic o, logic [2:0] b);
    return (s && w && !o) ? ~b : 3'b000;
  endfunction

  function automatic logic [23:0] exp_data(logic [2:0] d, logic [23:0] word);
    logic [23:0] r = '0;
    for (int i = 0; i < 3; i++) if (d[i]) r[i*8 +: 8] = word[i*8 +: 8];
    return r;
  endfunction

  // Drive at negedge, check mid-cycle, commit expectation at posedge.
  task automatic step(input logic [AW-1:0] a, input logic c0, input logic c1, input logic c2,
                      input logic w, input logic o, input logic [2:0] b, input logic [23:0] d,
                      input string ctx);
    logic s;
    logic [2:0] ed;
    string dtag;
    @(negedge clk);
    addr = a; cs0_n = c0; cs1_n = c1; cs2 = c2; we_n = w; oe_n = o; be_n = b; wdata = d;
    #2;
    s  = !c0 && !c1 && c2;
    ed = exp_drive(s, w, o, b);
    chk(standby == !s, {"R1 ", ctx}, {23'd0, standby}, {23'd0, !s});
    if (!s)      dtag = "R2";
    else if (!w) dtag = "R8";
    else if (o)  dtag = "R7";
    else         dtag = "R5";
    chk(drive == ed, {dtag, " drive ", ctx}, {21'd0, drive}, {21'd0, ed});
    chk(rdata == exp_data(ed, shadow[a]), {"R6 R5 data ", ctx}, rdata, exp_data(ed, shadow[a]));
    @(posedge clk);
    if (s && !w && rst_n)
      for (int i = 0; i < 3; i++) if (!b[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset state
    #5;
    chk(standby == 1'b1, "R1 reset standby", {23'd0, standby}, 24'd1);
    chk(drive == 3'b000, "R2 reset drive", {21'd0, drive}, 24'd0);
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;

    // fill every word, oe low during writes (R3, R11)
    for (int a = 0; a < DEPTH; a++)
      step(a[AW-1:0], 0, 0, 1, 0, a[0], 3'b000, {a[7:0] ^ 8'h3C, ~a[7:0], a[7:0] + 8'h11}, "R3 fill");
    for (int a = 0; a < DEPTH; a++)
      step(a[AW-1:0], 0, 0, 1, 1, 0, 3'b000, 24'hFFFFFF, "R11 readback");

    // R9 lane mapping: lane 0 only
    step(6'd5, 0, 0, 1, 0, 1, 3'b111, 24'h0, "R4 no lanes");
    step(6'd5, 0, 0, 1, 0, 0, 3'b110, 24'hAABBCC, "R9 lane0 write");
    step(6'd5, 0, 0, 1, 1, 0, 3'b000, 24'h0, "R9 R4 full read");
    step(6'd5, 0, 0, 1, 0, 1, 3'b011, 24'h123456, "R9 lane2 write");
    step(6'd5, 0, 0, 1, 1, 0, 3'b101, 24'h0, "R9 lane1 read");
    step(6'd5, 0, 0, 1, 1, 0, 3'b000, 24'h0, "R9 R4 full read");
    chk(rdata[23:16] == 8'h12 && rdata[7:0] == 8'hCC, "R9 lane placement", rdata,
        {8'h12, shadow[5][15:8], 8'hCC});

    // R2 partial selects try to write
    step(6'd9, 1, 0, 1, 0, 0, 3'b000, 24'hDEAD01, "R2 cs0 off");
    step(6'd9, 0, 1, 1, 0, 0, 3'b000, 24'hDEAD02, "R2 cs1 off");
    step(6'd9, 0, 0, 0, 0, 0, 3'b000, 24'hDEAD03, "R2 cs2 off");
    step(6'd9, 0, 0, 1, 1, 0, 3'b000, 24'h0, "R2 after");

    // R7 output off
    step(6'd9, 0, 0, 1, 1, 1, 3'b000, 24'h0, "R7 off");

    // R11 edges
    step(6'd0,  0, 0, 1, 0, 0, 3'b000, 24'h0F0F0F, "R11 first");
    step(6'd63, 0, 0, 1, 0, 0, 3'b000, 24'hF0F0F0, "R11 last");
    step(6'd0,  0, 0, 1, 1, 0, 3'b000, 24'h0, "R11 first rd");
    step(6'd63, 0, 0, 1, 1, 0, 3'b000, 24'h0, "R11 last rd");

    // R10 write during reset is dropped
    @(negedge clk);
    rst_n = 1'b0;
    addr = 6'd12; cs0_n = 0; cs1_n = 0; cs2 = 1; we_n = 0; oe_n = 1; be_n = 3'b000; wdata = 24'h5A5A5A;
    @(posedge clk);
    @(negedge clk);
    we_n = 1'b1;
    rst_n = 1'b1;
    step(6'd12, 0, 0, 1, 1, 0, 3'b000, 24'h0, "R10 reset write");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] cs;
      logic [31:0] r;
      r = $urandom;
      cs = (r[2:0] < 3'd6) ? 3'b001 : {r[5:4], r[6]};
      if (cs == 3'b001 && r[2:0] >= 3'd6) cs = 3'b101;
      step(r[12:7], cs[2], cs[1], cs[0], r[13], r[14], r[17:15], $urandom, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule